// File: doc/BRIEF.md
# CAN Bit Timing Segment Calculator

This block turns a handful of bus-level figures into the segment lengths of a CAN bit. It takes the total number of time quanta per bit, the signal propagation delay counted in module clock cycles, the clock prescaler (clock cycles per quantum) and the controller's information processing time in quanta.

A single-cycle start pulse launches one computation. The delay is first converted into whole quanta by repeated subtraction of the prescaler, rounding any partial quantum upward. A single combinational solver then does the rest:

- it reserves one quantum for synchronization;
- it divides the leftover quanta between the two phase buffer segments;
- it picks the widest permitted jump width;
- it packs all fields, each reduced by one, into a 15-bit configuration word.

A one-cycle done pulse marks the results. They stay on the outputs until the next accepted computation finishes. Any configuration that cannot be met raises an error flag, and in that case every segment output and the word read zero.

Top module: `bit_timing_calc`

## Requirements
- R1: After reset, done and err are 0, and every segment output and the word are 0.
- R2: prop_seg equals the delay divided by the prescaler, rounded up (a delay of 0 gives 0).
- R3: On success, prop_seg + phase1 + phase2 + 1 equals bit_tq.
- R4: The leftover count bit_tq - prop_seg - 1 is split between the two phase segments. An even leftover gives phase1 == phase2; an odd leftover gives phase2 == phase1 + 1.
- R5: sjw equals the smaller of 4 and phase1.
- R6: The configuration word is laid out as follows: bits 14:12 hold phase2-1, bits 11:8 hold phase1+prop_seg-1, bits 7:6 hold sjw-1, and bits 5:0 hold presc-1.
- R7: A leftover below 2 raises err, with all segment outputs and the word at 0.
- R8: err is raised when phase2 is below ipt, or when ipt is 3 (outside the range 0..2).
- R9: err is raised when a field does not fit. This covers phase2 above 8, phase1+prop_seg above 16, and a prescaler of 0 or above 64.
- R10: done is a one-cycle pulse. It rises ceil(delay/presc)+2 clock edges after the edge that accepts start (0 quanta when presc is 0).
- R11: start is ignored while a computation is in progress, and outputs hold. A start in the done cycle is accepted and begins a new computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a computation |
| bit_tq | input | 5 | Quanta per bit |
| delay_cyc | input | DLY_W | Propagation delay in clock cycles |
| presc | input | 7 | Clock cycles per quantum |
| ipt | input | 2 | Information processing time in quanta |
| done | output | 1 | Result valid pulse |
| err | output | 1 | Configuration cannot be met |
| prop_seg | output | 5 | Propagation segment in quanta |
| phase1 | output | 5 | First phase buffer segment |
| phase2 | output | 5 | Second phase buffer segment |
| sjw | output | 5 | Synchronization jump width |
| btr_word | output | 15 | Packed configuration word |

## Verification
Two events can fall in the same cycle: the done pulse of one computation and the acceptance of the next start. The bench provokes this by raising start on the very cycle done is seen. It then expects the following:
- the first result stays on the outputs throughout the second run;
- a second done arrives exactly at the latency of the second operand set;
- that second done carries the second result.

A start pulse in the middle of a long run is also applied. It must leave the latency and the result of that run untouched, and it must produce no extra done.

// File: rtl/bt_calc_pkg.sv
package bt_calc_pkg;
  localparam int TS2_W   = 3;
  localparam int TS1_W   = 4;
  localparam int SJW_W   = 2;
  localparam int BRP_W   = 6;
  localparam int WORD_W  = TS2_W + TS1_W + SJW_W + BRP_W;
  localparam int SEG_W   = 5;
  localparam int BT_W    = 5;
  localparam int PRE_W   = BRP_W + 1;
  localparam int IPT_W   = 2;
  localparam int IPT_MAX = 2;
  localparam int SJW_MAX = 1 << SJW_W;

  typedef struct packed {
    logic              ok;
    logic [SEG_W-1:0]  prop;
    logic [SEG_W-1:0]  ps1;
    logic [SEG_W-1:0]  ps2;
    logic [SEG_W-1:0]  sjw;
    logic [WORD_W-1:0] word;
  } bt_res_t;

  // Split the leftover quanta: the second phase takes the odd quantum.
  function automatic int unsigned lower_half(input int unsigned v);
    return v / 2;
  endfunction

  function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

  // Solve all segments from the rounded propagation quanta.
  function automatic bt_res_t bt_solve(input int unsigned bt, input int unsigned prop,
                                       input int unsigned presc, input int unsigned ipt);
    bt_res_t     r;
    int unsigned rem, p1, p2, sj;
    r   = '0;
    rem = 0;
    p1  = 0;
    p2  = 0;
    r.ok = 1'b1;
    if (presc < 1 || presc > (1 << BRP_W)) r.ok = 1'b0;
    if (ipt > IPT_MAX) r.ok = 1'b0;
    if (bt < prop + 3) begin
      r.ok = 1'b0;
    end else begin
      rem = bt - prop - 1;
      p1  = lower_half(rem);
      p2  = rem - p1;
    end
    if (p2 < ipt) r.ok = 1'b0;
    if (p2 > (1 << TS2_W)) r.ok = 1'b0;
    if (p1 + prop > (1 << TS1_W)) r.ok = 1'b0;
    sj = min_u(p1, SJW_MAX);
    if (r.ok) begin
      r.prop = SEG_W'(prop);
      r.ps1  = SEG_W'(p1);
      r.ps2  = SEG_W'(p2);
      r.sjw  = SEG_W'(sj);
      r.word = {TS2_W'(p2 - 1), TS1_W'(p1 + prop - 1), SJW_W'(sj - 1), BRP_W'(presc - 1)};
    end
    return r;
  endfunction
endpackage

// File: rtl/bt_ceil_div.sv
module bt_ceil_div #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quot,
  output logic         fin
);
  logic [W-1:0] rem_q, den_q;
  logic         run;
  logic         step_any, step_last;

  assign step_any  = run && (rem_q != '0);
  assign step_last = step_any && (rem_q <= den_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      den_q <= '0;
      quot  <= '0;
      run   <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        rem_q <= (den == '0) ? '0 : num;
        den_q <= den;
        quot  <= '0;
        run   <= 1'b1;
      end else if (run) begin
        if (rem_q == '0) begin
          run <= 1'b0;
          fin <= 1'b1;
        end else begin
          quot  <= quot + 1'b1;
          rem_q <= step_last ? '0 : rem_q - den_q;
        end
      end
    end
  end

  // R2: every active step adds one whole quantum
  p_quot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_any && !load |=> quot == $past(quot) + 1'b1);
  // R2: a partial remainder is rounded up and ends the division
  p_last_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_last && !load |=> rem_q == '0);
  // R10: finish is a single-cycle event
  p_fin_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
endmodule

// File: rtl/bit_timing_calc.sv
module bit_timing_calc
  import bt_calc_pkg::*;
#(
  parameter int DLY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BT_W-1:0]   bit_tq,
  input  logic [DLY_W-1:0]  delay_cyc,
  input  logic [PRE_W-1:0]  presc,
  input  logic [IPT_W-1:0]  ipt,
  output logic              done,
  output logic              err,
  output logic [SEG_W-1:0]  prop_seg,
  output logic [SEG_W-1:0]  phase1,
  output logic [SEG_W-1:0]  phase2,
  output logic [SEG_W-1:0]  sjw,
  output logic [WORD_W-1:0] btr_word
);
  logic              busy;
  logic              accept;
  logic [BT_W-1:0]   bt_q;
  logic [PRE_W-1:0]  pr_q;
  logic [IPT_W-1:0]  ip_q;
  logic [DLY_W-1:0]  quot;
  logic [DLY_W-1:0]  den_ext;
  logic              div_fin;
  logic              finish_now;
  bt_res_t           res;

  assign accept     = start && !busy;
  assign den_ext    = DLY_W'(presc);
  assign finish_now = busy && div_fin;

  bt_ceil_div #(.W(DLY_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept),
    .num  (delay_cyc),
    .den  (den_ext),
    .quot (quot),
    .fin  (div_fin)
  );

  always_comb res = bt_solve(32'(bt_q), 32'(quot), 32'(pr_q), 32'(ip_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      bt_q     <= '0;
      pr_q     <= '0;
      ip_q     <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      prop_seg <= '0;
      phase1   <= '0;
      phase2   <= '0;
      sjw      <= '0;
      btr_word <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        bt_q <= bit_tq;
        pr_q <= presc;
        ip_q <= ipt;
      end else if (finish_now) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        err      <= !res.ok;
        prop_seg <= res.prop;
        phase1   <= res.ps1;
        phase2   <= res.ps2;
        sjw      <= res.sjw;
        btr_word <= res.word;
      end
    end
  end

  // R10: done lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3: segments plus sync quantum fill the bit
  p_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> 32'(prop_seg) + 32'(phase1) + 32'(phase2) + 1 == 32'(bt_q));
  // R4: phases equal or second one longer by one
  p_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> (phase2 == phase1) || (phase2 == phase1 + 1'b1));
  // R5: jump width is min(4, phase1)
  p_sjw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> (sjw <= phase1) && (sjw <= 5'd4) && ((sjw == phase1) || (sjw == 5'd4)));
  // R7: error results carry no word
  p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> btr_word == '0 && prop_seg == '0);
  // R11: a start during a run leaves the captured operands alone
  p_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !div_fin |=> busy && $stable(bt_q) && $stable(pr_q));
endmodule

// File: tb/bit_timing_calc_tb.sv
module bit_timing_calc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct packed {
    logic [4:0]  bt;
    logic [9:0]  dly;
    logic [6:0]  pr;
    logic [1:0]  ip;
    logic        er;
    logic [4:0]  pp;
    logic [4:0]  p1;
    logic [4:0]  p2;
    logic [4:0]  sj;
    logic [14:0] wd;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{5'd10, 10'd6,   7'd1,  2'd2, 1'b0, 5'd6, 5'd1, 5'd2, 5'd1, 15'h1600}, // R4 odd, R6
    '{5'd16, 10'd10,  7'd4,  2'd1, 1'b0, 5'd3, 5'd6, 5'd6, 5'd4, 15'h58C3}, // R2 round up, R4 even
    '{5'd25, 10'd64,  7'd8,  2'd0, 1'b0, 5'd8, 5'd8, 5'd8, 5'd4, 15'h7FC7}, // R9 limits reached
    '{5'd8,  10'd5,   7'd5,  2'd2, 1'b0, 5'd1, 5'd3, 5'd3, 5'd3, 15'h2384}, // R5 sjw=phase1
    '{5'd9,  10'd0,   7'd64, 2'd2, 1'b0, 5'd0, 5'd4, 5'd4, 5'd4, 15'h33FF}, // R2 zero delay
    '{5'd12, 10'd7,   7'd2,  2'd2, 1'b0, 5'd4, 5'd3, 5'd4, 5'd3, 15'h3681}, // R4 odd
    '{5'd7,  10'd5,   7'd1,  2'd0, 1'b1, 5'd0, 5'd0, 5'd0, 5'd0, 15'h0000}, // R7 leftover 1
    '{5'd6,  10'd3,   7'd1,  2'd2, 1'b1, 5'd0, 5'd0, 5'd0, 5'd0, 15'h0000}, // R8 phase2<ipt
    '{5'd10, 10'd6,   7'd1,  2'd3, 1'b1, 5'd0, 5'd0, 5'd0, 5'd0, 15'h0000}, // R8 ipt 3
    '{5'd20, 10'd1,   7'd1,  2'd0, 1'b1, 5'd0, 5'd0, 5'd0, 5'd0, 15'h0000}, // R9 phase2 9
    '{5'd25, 10'd12,  7'd1,  2'd0, 1'b1, 5'd0, 5'd0, 5'd0, 5'd0, 15'h0000}, // R9 seg1 18
    '{5'd10, 10'd6,   7'd0,  2'd0, 1'b1, 5'd0, 5'd0, 5'd0, 5'd0, 15'h0000}, // R9 presc 0
    '{5'd10, 10'd65,  7'd65, 2'd0, 1'b1, 5'd0, 5'd0, 5'd0, 5'd0, 15'h0000}  // R9 presc 65
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  bit_tq = '0;
  logic [9:0]  delay_cyc = '0;
  logic [6:0]  presc = '0;
  logic [1:0]  ipt = '0;
  logic        done, err;
  logic [4:0]  prop_seg, phase1, phase2, sjw;
  logic [14:0] btr_word;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  bit_timing_calc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_tq(bit_tq), .delay_cyc(delay_cyc),
    .presc(presc), .ipt(ipt), .done(done), .err(err), .prop_seg(prop_seg),
    .phase1(phase1), .phase2(phase2), .sjw(sjw), .btr_word(btr_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input int d, input int p);
    return (p == 0) ? 2 : ((d + p - 1) / p) + 2;
  endfunction

  // Drive operands and a start pulse; count edges until done is seen.
  task automatic launch(input vec_t v);
    @(negedge clk);
    bit_tq = v.bt; delay_cyc = v.dly; presc = v.pr; ipt = v.ip; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!done && lat < 3000);
  endtask

  task automatic check_result(input string req, input vec_t v);
    chk({req, " err"},   32'(err),      32'(v.er));
    chk({req, " prop"},  32'(prop_seg), 32'(v.pp));
    chk({req, " ph1"},   32'(phase1),   32'(v.p1));
    chk({req, " ph2"},   32'(phase2),   32'(v.p2));
    chk({req, " sjw"},   32'(sjw),      32'(v.sj));
    chk({req, " word"},  32'(btr_word), 32'(v.wd));
  endtask

  initial begin
    int   lat;
    vec_t slow;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 done", 32'(done), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 word", 32'(btr_word), 0);
    chk("R1 segs", 32'({prop_seg, phase1, phase2, sjw}), 0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      launch(VECS[k]);
      wait_done(lat);
      // R10: latency; R2..R9: results per row comment
      chk($sformatf("R10 latency row %0d", k), 32'(lat), 32'(exp_lat(VECS[k].dly, VECS[k].pr)));
      check_result($sformatf("R2-row%0d", k), VECS[k]);
      @(negedge clk);
      chk($sformatf("R10 pulse row %0d", k), 32'(done), 0);
    end

    // R11: start in the middle of a long run is ignored
    slow = '{5'd18, 10'd15, 7'd1, 2'd0, 1'b0, 5'd15, 5'd1, 5'd1, 5'd1, 15'h0F00};
    launch(slow);
    repeat (4) @(negedge clk);
    bit_tq = VECS[0].bt; delay_cyc = VECS[0].dly; presc = VECS[0].pr; ipt = VECS[0].ip;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 5;
    while (!done && lat < 3000) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    chk("R11 latency unchanged", 32'(lat), 32'(exp_lat(15, 1)));
    check_result("R11 result unchanged", slow);
    begin
      int extra = 0;
      repeat (40) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk("R11 no extra done", 32'(extra), 0);
    end
    check_result("R11 outputs hold", slow);

    // R11: start raised in the done cycle is accepted
    launch(VECS[1]);
    wait_done(lat);
    bit_tq = VECS[0].bt; delay_cyc = VECS[0].dly; presc = VECS[0].pr; ipt = VECS[0].ip;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check_result("R11 first result held", VECS[1]);
    wait_done(lat);
    chk("R11 second latency", 32'(lat), 32'(exp_lat(6, 1)));
    check_result("R11 second result", VECS[0]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule